// File: doc/BRIEF.md
# Dual-clock FIFO with qualified reads and programmable flags

A first-in first-out buffer of 512 words of 18 bits whose write port and read port each run on their own clock. The two clocks may be unrelated or tied together. Each read cycle loads one stored word into an output register. A read happens only when the primary read strobe is active, the buffer holds data and every enabled read qualifier agrees. Status comes as four active-high flags: empty, almost empty, almost full and full.

A load-select line turns a clock edge on either port into an access to three small configuration registers instead of the buffer. The three registers are the almost-empty threshold, the almost-full threshold and a control word. Writes take their value from the data input. Reads place the value on the data output. In enhanced mode, reads also need an active-high second read strobe. If control bit 5 is set, the outputs must also be enabled for a read to happen, so a word is never consumed while the outputs are not driven. The three-state output is represented by a drive-enable signal.

Top module: `fifo18_gated`

## Requirements
- R1: After reset: empty=1, almost_empty=1, full=0, almost_full=0, dout=0, both thresholds=63, control word=0, and both configuration index pointers select the almost-empty threshold.
- R2: On a rising rclk edge with ld_n=1 and ren_n=0, and with the buffer not empty and the enhanced qualifiers satisfied, the next stored word is loaded into dout. Words leave in the order they were written.
- R3: While ren_n=1, dout keeps its value and the read pointer does not move.
- R4: While the buffer is empty, no read happens even with ren_n=0. After a word is written, empty clears within three rclk edges, and a held read strobe then loads that word.
- R5: A write (wclk rising, ld_n=1, wen_n=0) stores din unless full is set. After 512 unread words full=1, and a further write is discarded.
- R6: With enh=1, a read also needs ren2=1. With ren2=0 the read pointer and dout hold.
- R7: dout_drive equals the inverse of oe_n. In enhanced mode with control bit 5 set, oe_n=1 blocks reads. In compatible mode (enh=0), oe_n=1 does not block reads.
- R8: With ld_n=0, a wclk edge with wen_n=0 stores din[8:0] into the selected configuration register, and an rclk edge with ren_n=0 places the selected register on dout with bits 17:9 at zero. Both sides step through the registers in the order almost-empty threshold (index 0), almost-full threshold (1), control word (2), then wrap to 0. These accesses never change the buffer contents.
- R9: almost_empty=1 when the stored count is at or below the almost-empty threshold. almost_full=1 when the free space is at or below the almost-full threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Active-low write strobe |
| din | input | 18 | Write data, also the source for configuration writes |
| ld_n | input | 1 | Active-low select of configuration access |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Active-low primary read strobe |
| ren2 | input | 1 | Active-high second read strobe, used in enhanced mode |
| oe_n | input | 1 | Active-low output enable |
| enh | input | 1 | 1 selects enhanced mode, 0 compatible mode |
| dout | output | 18 | Output register |
| dout_drive | output | 1 | 1 when dout should be driven onto the bus |
| empty | output | 1 | Buffer holds no words (read domain) |
| almost_empty | output | 1 | Count at or below the almost-empty threshold (read domain) |
| almost_full | output | 1 | Free space at or below the almost-full threshold (write domain) |
| full | output | 1 | Buffer holds 512 words (write domain) |

## Verification
Some rules are checked by assertions on every edge of the matching clock:
- the read pointer never moves while empty, ren2 is low in enhanced mode, or the outputs are disabled under control bit 5;
- the read pointer never steps by more than one;
- the write pointer never moves while full;
- dout holds while the read strobe is idle.

Other behaviour can only be shown by the directed scenarios:
- words leave in the order they were written;
- the exact fill levels at which the almost flags switch;
- a held read strobe resumes after empty clears;
- the order in which the configuration registers are written and read back, including the wrap;
- compatible mode still reads while the outputs are disabled.

// File: rtl/fifo18_gated.sv
module fifo18_gated #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  input  logic          ld_n,
  input  logic          rclk,
  input  logic          ren_n,
  input  logic          ren2,
  input  logic          oe_n,
  input  logic          enh,
  output logic [DW-1:0] dout,
  output logic          dout_drive,
  output logic          empty,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [AW-1:0] OFF_RST = AW'(DEPTH / 8 - 1);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] wcount, rcount;
  logic [AW-1:0] ae_off, af_off, ctl_q, cfg_sel;
  logic [1:0]    widx, ridx;
  logic          wr_go, cfg_wr, rd_ok, rd_go, cfg_rd;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign wr_go  = ld_n & ~wen_n & ~full;
  assign cfg_wr = ~ld_n & ~wen_n;
  assign rd_ok  = ~ren_n & (~enh | ren2) & (~(enh & ctl_q[5]) | ~oe_n);
  assign rd_go  = ld_n & rd_ok & ~empty;
  assign cfg_rd = ~ld_n & ~ren_n;

  assign wcount      = wbin - g2b(rg_s2);
  assign full        = (wcount == DEPTH_P);
  assign almost_full = ((DEPTH_P - wcount) <= PW'(af_off));

  assign rcount       = g2b(wg_s2) - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= PW'(ae_off));

  assign dout_drive = ~oe_n;

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= din;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
      ae_off <= OFF_RST;
      af_off <= OFF_RST;
      ctl_q  <= '0;
      widx   <= 2'd0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (cfg_wr) begin
        case (widx)
          2'd0:    ae_off <= din[AW-1:0];
          2'd1:    af_off <= din[AW-1:0];
          default: ctl_q  <= din[AW-1:0];
        endcase
        widx <= (widx == 2'd2) ? 2'd0 : widx + 2'd1;
      end
    end
  end

  always_comb begin
    case (ridx)
      2'd0:    cfg_sel = ae_off;
      2'd1:    cfg_sel = af_off;
      default: cfg_sel = ctl_q;
    endcase
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      dout  <= '0;
      ridx  <= 2'd0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_go) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end else if (cfg_rd) begin
        dout <= DW'(cfg_sel);
        ridx <= (ridx == 2'd2) ? 2'd0 : ridx + 2'd1;
      end
    end
  end
endmodule

module fifo18_gated_chk #(
  parameter int PW = 10,
  parameter int DW = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          ren_n,
  input logic          ren2,
  input logic          oe_n,
  input logic          enh,
  input logic          ctl5,
  input logic          empty,
  input logic          full,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wptr,
  input logic [DW-1:0] dout
);
  AST_READ_STEP_ONE: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> (rptr == $past(rptr) || rptr == PW'($past(rptr) + 1'b1))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> ($stable(dout) && $stable(rptr))); // R3
  AST_NO_UNDERRUN: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |=> $stable(rptr)); // R4
  AST_NO_OVERRUN: assert property (@(posedge wclk) disable iff (!rst_n)
    full |=> $stable(wptr)); // R5
  AST_REN2_GATES: assert property (@(posedge rclk) disable iff (!rst_n)
    (enh && !ren2) |=> $stable(rptr)); // R6
  AST_OE_GATES: assert property (@(posedge rclk) disable iff (!rst_n)
    (enh && ctl5 && oe_n) |=> $stable(rptr)); // R7
endmodule

bind fifo18_gated fifo18_gated_chk #(.PW(AW + 1), .DW(DW)) chk_i (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .ren2(ren2),
  .oe_n(oe_n), .enh(enh), .ctl5(ctl_q[5]), .empty(empty), .full(full),
  .rptr(rbin), .wptr(wbin), .dout(dout)
);

// File: tb/fifo18_gated_tb.sv
module fifo18_gated_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;

  logic        rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
  logic        wen_n = 1'b1, ld_n = 1'b1, ren_n = 1'b1, ren2 = 1'b0;
  logic        oe_n = 1'b0, enh = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_drive, empty, almost_empty, almost_full, full;
  int          n_chk = 0, n_bad = 0;

  fifo18_gated dut_i (
    .rst_n(rst_n), .wclk(wclk), .wen_n(wen_n), .din(din), .ld_n(ld_n),
    .rclk(rclk), .ren_n(ren_n), .ren2(ren2), .oe_n(oe_n), .enh(enh),
    .dout(dout), .dout_drive(dout_drive), .empty(empty),
    .almost_empty(almost_empty), .almost_full(almost_full), .full(full)
  );

  always #(CLK_PERIOD / 2) wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] d);
    @(negedge wclk); wen_n = 1'b0; din = d;
    @(negedge wclk); wen_n = 1'b1;
  endtask

  task automatic rd();
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic t_reset();
    check("R1 empty", empty, 1);
    check("R1 almost_empty", almost_empty, 1);
    check("R1 full", full, 0);
    check("R1 almost_full", almost_full, 0);
    check("R1 dout", dout, 0);
    check("R7 drive with oe_n=0", dout_drive, 1);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) wr(18'h0A000 + 18'(i));
    settle();
    for (int i = 0; i < 5; i++) begin
      rd();
      check("R2 ordered read", dout, 18'h0A000 + 18'(i));
    end
    repeat (3) @(negedge rclk);
    check("R3 hold while idle", dout, 18'h0A004);
    check("R2 empty after drain", empty, 1);
  endtask

  task automatic t_empty();
    @(negedge rclk); ren_n = 1'b0;
    repeat (3) @(negedge rclk);
    check("R4 no read when empty", dout, 18'h0A004);
    wr(18'h2BEEF);
    settle();
    check("R4 read resumes", dout, 18'h2BEEF);
    check("R4 empty again", empty, 1);
    @(negedge rclk); ren_n = 1'b1;
  endtask

  task automatic t_flags();
    for (int i = 0; i < 512; i++) begin
      wr(18'(i));
      if (i == 62)  begin settle(); check("R9 ae at 63", almost_empty, 1); end
      if (i == 63)  begin settle(); check("R9 ae at 64", almost_empty, 0); end
      if (i == 447) begin settle(); check("R9 af at 448", almost_full, 0); end
      if (i == 448) begin settle(); check("R9 af at 449", almost_full, 1); end
      if (i == 510) begin settle(); check("R5 not full at 511", full, 0); end
    end
    settle();
    check("R5 full at 512", full, 1);
    wr(18'h3FFFF);
    settle();
    for (int i = 0; i < 512; i++) begin
      rd();
      check("R5 drained word", dout, 18'(i));
    end
    settle();
    check("R5 extra write dropped", empty, 1);
  endtask

  task automatic t_prog();
    ld_n = 1'b0;
    rd(); check("R1 ae threshold", dout, 63);
    rd(); check("R1 af threshold", dout, 63);
    rd(); check("R1 control word", dout, 0);
    wr(18'h3FF05); wr(18'h0000A); wr(18'h00020);
    settle();
    rd(); check("R8 ae readback", dout, 18'h00105);
    rd(); check("R8 af readback", dout, 18'h0000A);
    rd(); check("R8 ctl readback", dout, 18'h00020);
    wr(18'h00003);
    settle();
    rd(); check("R8 wrap to ae", dout, 18'h00003);
    ld_n = 1'b1;
    settle();
    check("R8 buffer untouched", empty, 1);
    for (int i = 0; i < 3; i++) wr(18'h01000 + 18'(i));
    settle();
    check("R9 ae at threshold 3", almost_empty, 1);
    wr(18'h01003);
    settle();
    check("R9 ae above threshold 3", almost_empty, 0);
    for (int i = 0; i < 4; i++) begin
      rd();
      check("R2 read after config", dout, 18'h01000 + 18'(i));
    end
  endtask

  task automatic t_enh();
    enh = 1'b0; oe_n = 1'b1;
    wr(18'h15555);
    settle();
    rd();
    check("R7 compat reads with oe_n=1", dout, 18'h15555);
    check("R7 drive off", dout_drive, 0);
    oe_n = 1'b0;
    #1 check("R7 drive on", dout_drive, 1);
    enh = 1'b1; ren2 = 1'b0;
    wr(18'h2AAAA);
    settle();
    rd();
    check("R6 ren2 low blocks", dout, 18'h15555);
    check("R6 word kept", empty, 0);
    ren2 = 1'b1; oe_n = 1'b1;
    rd();
    check("R7 oe_n blocks in enhanced", dout, 18'h15555);
    oe_n = 1'b0;
    rd();
    check("R6 read with ren2 high", dout, 18'h2AAAA);
    check("R6 drained", empty, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (2) @(negedge rclk);
    t_reset();
    t_order();
    t_empty();
    t_flags();
    t_prog();
    t_enh();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule